// File: doc/BRIEF.md
# Management Serial Bus Master (Clause 22 / Clause 45)

This block is a register-mapped master for the two-wire management bus that configures Ethernet PHYs. Software programs it through a small 32-bit register port with four words: configuration/status, command, data and address. It then produces the management clock and shifts complete frames onto a bidirectional data pin. The data pin is exposed as separate output, output-enable and input signals, so the pad can be built outside the block. One configuration bit selects the older short-address frame format (Clause 22) or the extended format with separate address frames (Clause 45).

Frames are started as side effects of register writes. Writing the data word starts a write frame. In Clause 45 mode, writing the address word starts an address frame. Writing the command word with its read bit set starts a read frame. Software polls the busy flag and then reads the result and the read-error flag. There is no valid/ready stream at any edge of this block. The register port is a single-cycle access with no back-pressure: a write that arrives while a frame is in flight is dropped rather than stalled. All pins are plain control and status signals.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration/status word reads 0, the clock output is low and the data output enable is low. The clock stays low whenever no frame is in progress.
- R2: The configuration/status word is at word address 12, the command word at 13, the data word at 14 and the address word at 15. Configuration/status bit 6 is the Clause 45 select and bits 15:8 are the divider. Bits 0 (busy) and 1 (read error) ignore writes. Command bits 4:0 are the device/register number, bits 9:5 the PHY number and bit 10 the preamble skip; command bit 15 always reads 0. The data and address words keep bits 15:0.
- R3: The clock period is 2*D system cycles, where D is the divider field. A divider of 0 behaves as 1.
- R4: A data-word write starts a write frame. The frame is 32 preamble ones, then the start code (01 for Clause 22, 00 for Clause 45), opcode 01, 5-bit PHY number, 5-bit device/register number, turnaround 10 and the 16 data bits. All fields are sent MSB first with the output enabled throughout.
- R5: In Clause 45 mode an address-word write starts a frame with start code 00, opcode 00 and the address word in the 16-bit payload. In Clause 22 mode it only stores the word and starts nothing.
- R6: A command-word write with bit 15 set starts a read frame with opcode 10 (Clause 22) or 11 (Clause 45). The output enable drops for the two turnaround bits and the 16 data bits.
- R7: When a read frame ends, busy clears and the data word holds the 16 bits sampled from the PHY, MSB first.
- R8: The read-error flag is set at the end of a read whose second turnaround bit was sampled high; the data word then holds the sampled bits, which are all ones when the line floats high. Each new read launch clears the flag.
- R9: With the preamble skip set, frames are sent without the 32 preamble ones.
- R10: While busy is set, every register write is ignored: no field changes and no frame starts.
- R11: The data output changes only when the clock falls (or at frame start, with the clock low). The input is sampled when the clock rises.
- R12: Busy reads 1 from the cycle after a launching write until the clock's last falling edge of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Word address of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The hardest situation to create from the ports is a register write that lands in the middle of a frame. Such a write must leave neither a changed field nor an extra frame behind. The bench issues data, command and configuration writes while a write frame is still shifting. After the frame it reads every affected word back, and it compares the total number of clock pulses against the sum of the expected frames, so any stray frame is counted. A second hard case is the missing PHY on a read. The bench's PHY model leaves the line high through the turnaround, then a later read answers properly to show the error flag clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // payload and header widths of one management frame (after the preamble)
  localparam int HDR_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int PORT_BITS  = 5;
  localparam int DEV_BITS   = 5;

  typedef enum logic [1:0] {
    FR_ADDR  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_e;

  typedef struct packed {
    logic                 c45;
    logic                 pre_off;
    frame_kind_e          kind;
    logic [PORT_BITS-1:0] port;
    logic [DEV_BITS-1:0]  dev;
    logic [DATA_BITS-1:0] payload;
  } frame_req_t;

endpackage

// File: rtl/mdio_frame_build.sv
// Assembles the full bit image of one frame, preamble on top, from a request.
module mdio_frame_build
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  localparam int FW     = PRE_LEN + HDR_BITS,
  localparam int IDX_W  = $clog2(FW)
) (
  input  frame_req_t        req,
  output logic [FW-1:0]     bits,
  output logic [IDX_W-1:0]  top_idx,
  output logic              is_read
);

  logic [1:0] st_code;
  logic [1:0] op_code;
  logic [1:0] ta_code;
  logic [DATA_BITS-1:0] pay;

  always_comb begin
    is_read = (req.kind == FR_READ);
    st_code = req.c45 ? 2'b00 : 2'b01;
    case (req.kind)
      FR_ADDR:  op_code = 2'b00;
      FR_WRITE: op_code = 2'b01;
      FR_READ:  op_code = req.c45 ? 2'b11 : 2'b10;
      default:  op_code = 2'b01;
    endcase
    // on a read the master does not drive these bits; keep them idle-high
    ta_code = is_read ? 2'b11 : 2'b10;
    pay     = is_read ? {DATA_BITS{1'b1}} : req.payload;
    bits    = {{PRE_LEN{1'b1}}, st_code, op_code, req.port, req.dev, ta_code, pay};
    top_idx = req.pre_off ? IDX_W'(HDR_BITS - 1) : IDX_W'(FW - 1);
  end

endmodule

// File: rtl/mdio_bit_timer.sv
// Half-period counter that toggles the management clock and flags its edges.
module mdio_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick = run && (cnt_q == half - DIV_W'(1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc   <= !mdc;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/mdio_engine.sv
// Shifts one frame out per start pulse and collects read data.
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8,
  localparam int FW     = PRE_LEN + HDR_BITS,
  localparam int IDX_W  = $clog2(FW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  frame_req_t           req,
  input  logic [DIV_W-1:0]     div,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 rd_done,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 ta_err,
  output logic                 mdc_o,
  output logic                 mdio_o,
  output logic                 mdio_oe
);

  // bit positions counted down to 0 at the last data bit
  localparam logic [IDX_W-1:0] TA2_IDX = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] REL_IDX = IDX_W'(DATA_BITS + 1);

  logic [FW-1:0]        fb_bits;
  logic [IDX_W-1:0]     fb_top;
  logic                 fb_rd;

  logic [FW-1:0]        sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 rd_q;
  logic                 busy_q;
  logic                 ta_bad_q;
  logic [DATA_BITS-1:0] rx_q;
  logic [DIV_W-1:0]     half_q;
  logic                 rise;
  logic                 fall;

  mdio_frame_build #(.PRE_LEN(PRE_LEN)) u_build (
    .req     (req),
    .bits    (fb_bits),
    .top_idx (fb_top),
    .is_read (fb_rd)
  );

  mdio_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .half  (half_q),
    .mdc   (mdc_o),
    .rise  (rise),
    .fall  (fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      idx_q    <= '0;
      rd_q     <= 1'b0;
      busy_q   <= 1'b0;
      ta_bad_q <= 1'b0;
      rx_q     <= '0;
      half_q   <= DIV_W'(1);
    end else if (start && !busy_q) begin
      sh_q     <= fb_bits;
      idx_q    <= fb_top;
      rd_q     <= fb_rd;
      busy_q   <= 1'b1;
      ta_bad_q <= 1'b0;
      rx_q     <= '0;
      half_q   <= (div == '0) ? DIV_W'(1) : div;
    end else if (busy_q) begin
      if (rise && rd_q) begin
        if (idx_q == TA2_IDX) begin
          ta_bad_q <= mdio_i;
        end else if (idx_q < TA2_IDX) begin
          rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
        end
      end
      if (fall) begin
        if (idx_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q - IDX_W'(1);
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && fall && (idx_q == '0);
  assign rd_done = done && rd_q;
  assign rx_data = rx_q;
  assign ta_err  = ta_bad_q;
  assign mdio_o  = busy_q ? sh_q[idx_q] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (idx_q <= REL_IDX));

endmodule

// File: rtl/mdio_regs.sv
// Register words, launch decode and result capture.
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFF_STAT = 12,
  parameter int OFF_CMD  = 13,
  parameter int OFF_DATA = 14,
  parameter int OFF_ADDR = 15,
  parameter int DIV_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 eng_busy,
  input  logic                 rd_done,
  input  logic [DATA_BITS-1:0] rx_data,
  input  logic                 ta_err,
  output logic                 start,
  output frame_req_t           req,
  output logic [DIV_W-1:0]     div,
  output logic                 busy_all,
  output logic                 rd_err
);

  localparam int BIT_BUSY = 0;
  localparam int BIT_RERR = 1;
  localparam int BIT_C45  = 6;
  localparam int DIV_LSB  = 8;
  localparam int BIT_PREOFF = 10;
  localparam int BIT_RDREQ  = 15;
  localparam int PORT_LSB   = DEV_BITS;

  logic                 c45_q;
  logic [DIV_W-1:0]     div_q;
  logic [PORT_BITS-1:0] port_q;
  logic [DEV_BITS-1:0]  dev_q;
  logic                 pre_off_q;
  logic [DATA_BITS-1:0] data_q;
  logic [DATA_BITS-1:0] addr_q;
  logic                 rerr_q;
  logic                 pend_q;
  frame_kind_e          kind_q;

  logic acc;
  logic hit_stat, hit_cmd, hit_data, hit_addr;

  assign hit_stat = (reg_addr == ADDR_W'(OFF_STAT));
  assign hit_cmd  = (reg_addr == ADDR_W'(OFF_CMD));
  assign hit_data = (reg_addr == ADDR_W'(OFF_DATA));
  assign hit_addr = (reg_addr == ADDR_W'(OFF_ADDR));
  assign busy_all = pend_q || eng_busy;
  assign acc      = reg_we && !busy_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q     <= 1'b0;
      div_q     <= '0;
      port_q    <= '0;
      dev_q     <= '0;
      pre_off_q <= 1'b0;
      data_q    <= '0;
      addr_q    <= '0;
      rerr_q    <= 1'b0;
      pend_q    <= 1'b0;
      kind_q    <= FR_WRITE;
    end else begin
      pend_q <= 1'b0;
      if (rd_done) begin
        data_q <= rx_data;
        rerr_q <= ta_err;
      end
      if (acc) begin
        if (hit_stat) begin
          c45_q <= reg_wdata[BIT_C45];
          div_q <= reg_wdata[DIV_LSB +: DIV_W];
        end
        if (hit_cmd) begin
          dev_q     <= reg_wdata[DEV_BITS-1:0];
          port_q    <= reg_wdata[PORT_LSB +: PORT_BITS];
          pre_off_q <= reg_wdata[BIT_PREOFF];
          if (reg_wdata[BIT_RDREQ]) begin
            pend_q <= 1'b1;
            kind_q <= FR_READ;
            rerr_q <= 1'b0;
          end
        end
        if (hit_data) begin
          data_q <= reg_wdata[DATA_BITS-1:0];
          pend_q <= 1'b1;
          kind_q <= FR_WRITE;
        end
        if (hit_addr) begin
          addr_q <= reg_wdata[DATA_BITS-1:0];
          if (c45_q) begin
            pend_q <= 1'b1;
            kind_q <= FR_ADDR;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_stat) begin
      reg_rdata[BIT_BUSY]           = busy_all;
      reg_rdata[BIT_RERR]           = rerr_q;
      reg_rdata[BIT_C45]            = c45_q;
      reg_rdata[DIV_LSB +: DIV_W]   = div_q;
    end else if (hit_cmd) begin
      reg_rdata[DEV_BITS-1:0]       = dev_q;
      reg_rdata[PORT_LSB +: PORT_BITS] = port_q;
      reg_rdata[BIT_PREOFF]         = pre_off_q;
    end else if (hit_data) begin
      reg_rdata[DATA_BITS-1:0]      = data_q;
    end else if (hit_addr) begin
      reg_rdata[DATA_BITS-1:0]      = addr_q;
    end
  end

  assign start       = pend_q;
  assign div         = div_q;
  assign rd_err      = rerr_q;
  assign req.c45     = c45_q;
  assign req.pre_off = pre_off_q;
  assign req.kind    = kind_q;
  assign req.port    = port_q;
  assign req.dev     = dev_q;
  assign req.payload = (kind_q == FR_ADDR) ? addr_q : data_q;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[14:11]};

endmodule

// File: rtl/mdio_master.sv
// Top level: register port plus frame engine for the PHY management bus.
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFF_STAT = 12,
  parameter int OFF_CMD  = 13,
  parameter int OFF_DATA = 14,
  parameter int OFF_ADDR = 15,
  parameter int PRE_LEN  = 32,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic                 start;
  frame_req_t           req;
  logic [DIV_W-1:0]     div;
  logic                 eng_busy;
  logic                 busy_all;
  logic                 done;
  logic                 rd_done;
  logic [DATA_BITS-1:0] rx_data;
  logic                 ta_err;
  logic                 rd_err_w;

  mdio_regs #(
    .ADDR_W(ADDR_W), .OFF_STAT(OFF_STAT), .OFF_CMD(OFF_CMD),
    .OFF_DATA(OFF_DATA), .OFF_ADDR(OFF_ADDR), .DIV_W(DIV_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_busy  (eng_busy),
    .rd_done   (rd_done),
    .rx_data   (rx_data),
    .ta_err    (ta_err),
    .start     (start),
    .req       (req),
    .div       (div),
    .busy_all  (busy_all),
    .rd_err    (rd_err_w)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .req     (req),
    .div     (div),
    .mdio_i  (mdio_i),
    .busy    (eng_busy),
    .done    (done),
    .rd_done (rd_done),
    .rx_data (rx_data),
    .ta_err  (ta_err),
    .mdc_o   (mdc_o),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  logic unused_sig;
  assign unused_sig = done ^ busy_all;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic rd_err
);

  // R1
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R11
  data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !($past(mdc) && !mdc)) |-> $stable(mdio_o));

  // R12
  frame_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we, 2));

  // R8
  rderr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> $fell(busy));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_we  (reg_we),
  .mdc     (mdc_o),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (eng_busy),
  .rd_err  (rd_err_w)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int CLK_PERIOD = 10;
  localparam int A_STAT = 12;
  localparam int A_CMD  = 13;
  localparam int A_DATA = 14;
  localparam int A_ADDR = 15;

  typedef struct {
    int          n;
    logic [63:0] bits;
    logic [63:0] oe;
    logic [63:0] resp;
    int          half;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int exp_rises = 0;
  bit fin = 1'b0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = !clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc_o) rises++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic item_t mk(bit c45, bit pre_off, int kind, logic [4:0] port,
                               logic [4:0] dev, logic [15:0] pay, bit phy, int half, string tag);
    item_t it;
    logic [1:0] st, op, ta;
    logic [31:0] f;
    st = c45 ? 2'b00 : 2'b01;
    op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (c45 ? 2'b11 : 2'b10);
    ta = (kind == 2) ? 2'b11 : 2'b10;
    f  = {st, op, port, dev, ta, (kind == 2) ? 16'hFFFF : pay};
    it.n    = pre_off ? 32 : 64;
    it.bits = {32'hFFFF_FFFF, f};
    it.oe   = '1;
    it.resp = '1;
    if (kind == 2) begin
      it.oe[17:0] = '0;
      if (phy) begin
        it.resp[16]   = 1'b0;
        it.resp[15:0] = pay;
      end
    end
    it.half = half;
    it.tag  = tag;
    return it;
  endfunction

  task automatic push(input item_t it);
    q.push_back(it);
    exp_rises += it.n;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = 4'(a);
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h1;
    for (int i = 0; i < 20000 && s[0]; i++) rd(A_STAT, s);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor with PHY responder
  initial begin
    item_t it;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      begin
        int mism;
        time t0, t1;
        mism = 0; t0 = 0; t1 = 0;
        for (int k = 0; k < it.n; k++) begin
          int idx;
          idx = it.n - 1 - k;
          mdio_i = it.resp[idx];
          @(posedge mdc_o);
          if (k == 0) t0 = $time;
          if (k == 1) t1 = $time;
          if (it.oe[idx] !== mdio_oe) mism++;
          if (it.oe[idx] && (it.bits[idx] !== mdio_o)) mism++;
          @(negedge mdc_o);
        end
        mdio_i = 1'b1;
        chk(mism == 0, {it.tag, " frame bits"}, 32'(mism), 32'd0);
        chk((t1 - t0) == time'(2 * it.half * CLK_PERIOD), "R3 clock period",
            32'(t1 - t0), 32'(2 * it.half * CLK_PERIOD));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d);  chk(d == 32'h0, "R1 status after reset", d, 32'h0);
    chk({mdc_o, mdio_oe} == 2'b00, "R1 clock and enable low", {30'b0, mdc_o, mdio_oe}, 32'h0);

    // R2 register fields; busy/error bits ignore writes
    wr(A_STAT, 32'h0000_0143);
    rd(A_STAT, d);  chk(d == 32'h0000_0140, "R2 status readback", d, 32'h0000_0140);
    wr(A_STAT, 32'h0000_0100);
    wr(A_CMD, 32'h0000_80A3 & 32'h0000_07FF);
    rd(A_CMD, d);   chk(d == 32'h0000_00A3, "R2 command readback", d, 32'h0000_00A3);

    // R4 Clause 22 write with preamble, R12 busy
    push(mk(0, 0, 1, 5'd5, 5'd3, 16'hA5C3, 0, 1, "R4 c22 write"));
    wr(A_DATA, 32'h0000_A5C3);
    rd(A_STAT, d);  chk(d[0] == 1'b1, "R12 busy after launch", d, 32'h1);
    // R10 writes while busy are dropped
    wr(A_DATA, 32'h0000_1111);
    wr(A_CMD, 32'h0000_8000 | 32'h0000_0421);
    wr(A_STAT, 32'h0000_0540);
    wait_idle();
    rd(A_STAT, d);  chk(d == 32'h0000_0100, "R10 status unchanged", d, 32'h0000_0100);
    rd(A_DATA, d);  chk(d == 32'h0000_A5C3, "R10 data unchanged", d, 32'h0000_A5C3);
    rd(A_CMD, d);   chk(d == 32'h0000_00A3, "R10 command unchanged", d, 32'h0000_00A3);

    // R6/R7 Clause 22 read with PHY answering
    push(mk(0, 0, 2, 5'd5, 5'd3, 16'h1234, 1, 1, "R6 c22 read"));
    wr(A_CMD, 32'h0000_80A3);
    wait_idle();
    rd(A_DATA, d);  chk(d == 32'h0000_1234, "R7 read result", d, 32'h0000_1234);
    rd(A_STAT, d);  chk(d[1] == 1'b0, "R8 no error on answered read", d, 32'h0);

    // R8 read without PHY
    push(mk(0, 0, 2, 5'd9, 5'd1, 16'h0000, 0, 1, "R8 c22 read no phy"));
    wr(A_CMD, 32'h0000_8121);
    wait_idle();
    rd(A_STAT, d);  chk(d == 32'h0000_0102, "R8 error flag set", d, 32'h0000_0102);
    rd(A_DATA, d);  chk(d == 32'h0000_FFFF, "R8 floating data", d, 32'h0000_FFFF);
    push(mk(0, 0, 2, 5'd9, 5'd1, 16'h0F0F, 1, 1, "R8 c22 read after error"));
    wr(A_CMD, 32'h0000_8121);
    wait_idle();
    rd(A_STAT, d);  chk(d[1] == 1'b0, "R8 error cleared", d, 32'h0);
    rd(A_DATA, d);  chk(d == 32'h0000_0F0F, "R7 second read result", d, 32'h0000_0F0F);

    // R5 Clause 22 address write starts nothing
    wr(A_ADDR, 32'h0000_4321);
    rd(A_STAT, d);  chk(d[0] == 1'b0, "R5 c22 address no frame", d, 32'h0);
    rd(A_ADDR, d);  chk(d == 32'h0000_4321, "R5 address stored", d, 32'h0000_4321);

    // Clause 45, divider 3
    wr(A_STAT, 32'h0000_0340);
    wr(A_CMD, 32'h0000_0041);
    push(mk(1, 0, 0, 5'd2, 5'd1, 16'hBEEF, 0, 3, "R5 c45 address frame"));
    wr(A_ADDR, 32'h0000_BEEF);
    wait_idle();
    // R9 preamble skip, Clause 45 write
    wr(A_CMD, 32'h0000_0441);
    push(mk(1, 1, 1, 5'd2, 5'd1, 16'h7E81, 0, 3, "R9 c45 write no preamble"));
    wr(A_DATA, 32'h0000_7E81);
    wait_idle();
    // R6 Clause 45 read, no preamble
    push(mk(1, 1, 2, 5'd2, 5'd1, 16'h5A5A, 1, 3, "R6 c45 read"));
    wr(A_CMD, 32'h0000_8441);
    wait_idle();
    rd(A_DATA, d);  chk(d == 32'h0000_5A5A, "R7 c45 read result", d, 32'h0000_5A5A);

    // R3 divider 0 behaves as 1
    wr(A_STAT, 32'h0000_0040);
    push(mk(1, 1, 1, 5'd2, 5'd1, 16'h0001, 0, 1, "R3 divider zero write"));
    wr(A_DATA, 32'h0000_0001);
    wait_idle();

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R10 all expected frames seen", 32'(q.size()), 32'd0);
    chk(rises == exp_rises, "R10 no stray frames", 32'(rises), 32'(exp_rises));
    chk(mdc_o == 1'b0, "R1 clock idle low", {31'b0, mdc_o}, 32'h0);

    fin = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule